// File: doc/BRIEF.md
# Toggle-Refreshed Hardware Watchdog Timer

This block watches a single refresh line driven by software through a general-purpose port bit. A second input, the direction flag of that bit, arms the watchdog: while the bit is set as an output the watchdog counts, and while it is set as an input the watchdog is idle with its counter held at zero. Software services the watchdog by changing the level of the refresh line. A rising change and a falling change both count. If no change arrives within the configured number of clock cycles, the block raises a reset request for a fixed number of cycles.

The refresh line passes through a synchronizer before a change is detected, so it may come from any clock domain. Arming the watchdog counts as a refresh. After a reset pulse ends, the counter starts again from zero. For a one-second minimum timeout, set `TIMEOUT_CYCLES` to the clock rate in hertz.

Top module: `toggle_wdt`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `wdt_rst_o` is 0 and the watchdog is disarmed.
- R2: While `dir_out_i` is 0 (the port bit is an input), `wdt_rst_o` never rises, whatever the refresh line does and however long the watchdog stays in this state.
- R3: The watchdog arms at the first rising clock edge that samples `dir_out_i` = 1 while it is disarmed. That edge counts as a refresh. With no later refresh, `wdt_rst_o` rises exactly `TIMEOUT_CYCLES` rising edges after that edge.
- R4: Any change of level on `refresh_i`, rising or falling, is a refresh. Counting the first clock edge that samples the new level as edge 0, the refresh takes effect at edge 2. With no later refresh, `wdt_rst_o` rises at edge `TIMEOUT_CYCLES + 2`.
- R5: While the watchdog is armed, refresh changes spaced closer than `TIMEOUT_CYCLES` cycles keep `wdt_rst_o` at 0.
- R6: Each reset pulse holds `wdt_rst_o` at 1 for exactly `PULSE_CYCLES` cycles.
- R7: If the watchdog is still armed when a pulse ends and no refresh follows, the next pulse rises `TIMEOUT_CYCLES + PULSE_CYCLES` cycles after the previous one rose.
- R8: Setting `dir_out_i` to 0 in the middle of a count clears the count. Arming again restarts the full timeout, as R3 states.
- R9: A refresh change during a reset pulse has no effect on that pulse's length or on the time of the next pulse given in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| refresh_i | input | 1 | Refresh line; any change of level services the watchdog |
| dir_out_i | input | 1 | 1 when the refresh port bit is an output (armed), 0 when it is an input |
| wdt_rst_o | output | 1 | Registered reset request, high for `PULSE_CYCLES` cycles on expiry |

## Verification
The assertions assume that `dir_out_i` is synchronous to `clk` and that `rst` is held for at least one edge at start-up. They make no assumption about how often `refresh_i` changes. The stimulus changes `dir_out_i` and `refresh_i` only on falling clock edges, so each change is sampled at one known rising edge. Every expected reset edge is computed from that edge. A scoreboard then compares each observed rising edge and each pulse width of `wdt_rst_o` against a queue of expected events. Any reset that has no expected event queued is reported as a failure.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIRE = 2'd2
  } wdt_state_e;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic change_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= async_i;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign change_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval #(
  parameter int LIMIT = 200_000_000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_i,
  output logic                     expire_o,
  output logic [$clog2(LIMIT)-1:0] cnt_o
);
  localparam int CW = $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = !clr_i && (cnt_q == LAST);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i || expire_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic pulse_o,
  output logic done_o
);
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [PW-1:0] left_q;

  assign done_o = pulse_o && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      left_q  <= '0;
    end else if (start_i) begin
      pulse_o <= 1'b1;
      left_q  <= PW'(WIDTH - 1);
    end else if (pulse_o) begin
      if (left_q == '0) pulse_o <= 1'b0;
      else              left_q  <= left_q - 1'b1;
    end
  end

  // R6
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> ($past(left_q) == '0));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !(start_i && pulse_o));
endmodule

// File: rtl/toggle_wdt.sv
module toggle_wdt #(
  parameter int TIMEOUT_CYCLES = 200_000_000,
  parameter int PULSE_CYCLES   = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refresh_i,
  input  logic dir_out_i,
  output logic wdt_rst_o
);
  import wdt_pkg::*;

  localparam int CW = $clog2(TIMEOUT_CYCLES);

  wdt_state_e    state_q;
  logic          change_w;
  logic          clr_w;
  logic          expire_w;
  logic          done_w;
  logic [CW-1:0] cnt_w;

  wdt_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_i  (refresh_i),
    .change_o (change_w)
  );

  assign clr_w = (state_q != ST_RUN) || !dir_out_i || change_w;

  wdt_interval #(.LIMIT(TIMEOUT_CYCLES)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr_w),
    .expire_o (expire_w),
    .cnt_o    (cnt_w)
  );

  wdt_stretch #(.WIDTH(PULSE_CYCLES)) pulse_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (expire_w),
    .pulse_o (wdt_rst_o),
    .done_o  (done_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:  if (dir_out_i) state_q <= ST_RUN;
        ST_RUN:  if (!dir_out_i)    state_q <= ST_OFF;
                 else if (expire_w) state_q <= ST_FIRE;
        ST_FIRE: if (done_w) state_q <= dir_out_i ? ST_RUN : ST_OFF;
        default: state_q <= ST_OFF;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!wdt_rst_o && state_q == ST_OFF));

  // R2
  armed_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) |-> ($past(dir_out_i) && $past(state_q) == ST_RUN));

  // R4
  refresh_block_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) |-> !$past(change_w));

  // R7
  fire_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIRE) |-> (cnt_w == '0));
endmodule

// File: tb/toggle_wdt_tb_top.sv
`timescale 1ns/1ps
module toggle_wdt_tb_top;
  localparam int T = 40;
  localparam int P = 16;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refresh_i = 1'b0;
  logic dir_out_i = 1'b0;
  logic wdt_rst_o;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   rise_cnt = 0;
  int   last_rise = 0;
  logic prev_o = 1'b0;
  exp_t expq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  toggle_wdt #(.TIMEOUT_CYCLES(T), .PULSE_CYCLES(P), .SYNC_STAGES(2)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .refresh_i (refresh_i),
    .dir_out_i (dir_out_i),
    .wdt_rst_o (wdt_rst_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int c, input string tag);
    exp_t e;
    e.cyc = c;
    e.tag = tag;
    expq.push_back(e);
  endtask

  // Returns the cycle count at the negedge of the final change.
  task automatic toggle_to(input logic v, output int c);
    if (refresh_i == v) begin
      refresh_i = ~v;
      tick(5);
    end
    refresh_i = v;
    c = cyc;
  endtask

  task automatic wait_rises(input int target);
    while (rise_cnt < target) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (wdt_rst_o && !prev_o) begin
      if (expq.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R2/R5: actual reset at %0d expected none", cyc);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(cyc == e.cyc, e.tag, cyc, e.cyc);
      end
      last_rise = cyc;
      rise_cnt  = rise_cnt + 1;
    end else if (!wdt_rst_o && prev_o) begin
      chk((cyc - last_rise) == P, "R6", cyc - last_rise, P);
    end
    prev_o = wdt_rst_o;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    int c;
    int rc;
    tick(2);
    chk(wdt_rst_o == 1'b0, "R1", wdt_rst_o, 0);
    tick(3);
    rst = 1'b0;
    tick(1);
    chk(wdt_rst_o == 1'b0, "R1", wdt_rst_o, 0);

    // R2: disarmed, with refresh changes and long idle spans
    rc = rise_cnt;
    for (int i = 0; i < 12; i++) begin
      refresh_i = ~refresh_i;
      tick(7);
    end
    tick(3 * T);
    chk(wdt_rst_o == 1'b0, "R2", wdt_rst_o, 0);
    chk(rise_cnt == rc, "R2", rise_cnt, rc);

    // R3: arm with no refresh
    dir_out_i = 1'b1;
    push(cyc + 1 + T, "R3");
    wait_rises(rc + 1);
    tick(1);
    dir_out_i = 1'b0;
    tick(P + 5);

    // R5: regular refresh keeps the output low
    rc = rise_cnt;
    dir_out_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick(T / 2);
      refresh_i = ~refresh_i;
    end
    tick(T / 2);
    chk(rise_cnt == rc, "R5", rise_cnt, rc);
    // R4 (rising change), then R7 repeat
    toggle_to(1'b1, c);
    push(c + 3 + T, "R4");
    push(c + 3 + T + T + P, "R7");
    wait_rises(rc + 2);
    tick(1);
    dir_out_i = 1'b0;
    tick(P + 5);

    // R4 (falling change) supersedes the arming refresh
    rc = rise_cnt;
    dir_out_i = 1'b1;
    tick(10);
    toggle_to(1'b0, c);
    push(c + 3 + T, "R4");
    wait_rises(rc + 1);
    tick(1);
    dir_out_i = 1'b0;
    tick(P + 5);

    // R8: disarm mid-count, rearm restarts the full timeout
    rc = rise_cnt;
    dir_out_i = 1'b1;
    tick(T - 5);
    dir_out_i = 1'b0;
    tick(3);
    dir_out_i = 1'b1;
    push(cyc + 1 + T, "R8");
    wait_rises(rc + 1);
    // R9: a refresh during the pulse changes nothing
    push(last_rise + P + T, "R9");
    tick(1);
    refresh_i = ~refresh_i;
    wait_rises(rc + 2);
    tick(1);
    dir_out_i = 1'b0;
    tick(P + 5);

    // R2: quiet tail while disarmed
    rc = rise_cnt;
    tick(2 * T);
    chk(rise_cnt == rc, "R2", rise_cnt, rc);
    chk(expq.size() == 0, "R3", expq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule